// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block lets a management controller that speaks only 16-bit clause 22 register accesses reach a 32-bit internal register space. The front end receives register transactions that have already been decoded: a strobe, a direction, a 5-bit register number and 16 bits of write data. The back end is a simple 32-bit register bus with a byte address, write data, a write enable, a read strobe and read data.

The internal byte address is split across the MDIO register map:

- Address bits [15:6] form a page. Software loads the page by writing register 31.
- Address bits [5:2] pick one of sixteen words within the page. The word is chosen by the register number 0 to 15, and that register carries the low half of the word.
- Register 16 carries the upper half.
- Address bits [1:0] are always zero on the bus.

A full write is three transactions: page, low half, upper half. The bus write happens on the upper-half write. A full read is also three transactions: page, low half, upper half. The bus read happens on the low-half read, and the upper half is kept for the read of register 16.

The requester issues one transaction at a time. After a read it waits for the response strobe before it issues the next request.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset `busWe`, `busRe` and `mdioRvalid` are low, and reads of register 31 and of register 16 both return 0.
- R2: A write to register 31 loads the page from write data bits [PAGE_W-1:0]. A later read of register 31 returns the page, zero-extended, with `mdioRvalid` high one cycle after the request cycle.
- R3: A write to a register from 0 to 15 stores the data and the register number and causes no bus write.
- R4: A write to register 16 makes `busWe` high for exactly one cycle, the cycle after the request. The bus address is {page, stored index, 2'b00} and the bus data is {register 16 data, stored low half}.
- R5: A read of a register n from 0 to 15 makes `busRe` high for exactly one cycle, the cycle after the request, with address {page, n, 2'b00}. The requester gets `busRdata[15:0]` with `mdioRvalid` high three cycles after the request cycle.
- R6: A read of register 16 returns `busRdata[31:16]` as captured by the most recent low-half read. It makes no bus access and responds one cycle after the request.
- R7: Registers 17 to 30 read as 0 and make no bus access. Writes to them change neither the page nor a pending low half.
- R8: The index used by a register 16 write is the one from the most recent low-half write, even if low-half reads came in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mdioReq | input | 1 | One-cycle request strobe for a decoded MDIO transaction |
| mdioWrite | input | 1 | 1 = register write, 0 = register read |
| mdioReg | input | REG_W | MDIO register number |
| mdioWdata | input | HALF_W | Write data of the transaction |
| mdioRdata | output | HALF_W | Read data returned to the requester |
| mdioRvalid | output | 1 | One-cycle strobe marking `mdioRdata` valid |
| busAddr | output | PAGE_W+IDX_W+2 | Internal byte address |
| busWdata | output | 2*HALF_W | Internal write data |
| busWe | output | 1 | One-cycle internal write strobe |
| busRe | output | 1 | One-cycle internal read strobe |
| busRdata | input | 2*HALF_W | Internal read data, valid the cycle after `busRe` |

## Verification
The bench builds the block with its default values: a 10-bit page, a 4-bit word index, 16-bit halves and 5-bit register numbers.

With those values it writes and then reads back every one of the sixteen word slots in four pages, including page 0 and the all-ones page. The data of each slot is a value computed from its address, and the bench checks the address and data of every bus strobe.

It then sweeps all fourteen unused register numbers with both reads and writes. It also interleaves low-half reads between a low-half write and its upper-half write, to confirm which index and low half reach the bus.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic loadPage;    // write to page register
    logic loadLow;     // hold low half and index of a write
    logic issueWr;     // launch internal write
    logic issueRd;     // launch internal read
    logic captureRd;   // take internal read data
    logic respDirect;  // answer a read from local state
  } ctlStrb_t;
endpackage

// File: rtl/mpb_ctrl.sv
module mpb_ctrl
  import mpb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mdioReq,
  input  logic             mdioWrite,
  input  logic [REG_W-1:0] mdioReg,
  output ctlStrb_t         strb
);
  localparam logic [REG_W-1:0] HI_REG   = REG_W'(2 ** IDX_W);
  localparam logic [REG_W-1:0] PAGE_REG = REG_W'(2 ** REG_W - 1);

  typedef enum logic [1:0] {IDLE, RD_BUS, RD_CAP} ctlState_t;
  ctlState_t state, stateNxt;

  logic isLow, isHi, isPage;
  assign isLow  = mdioReg < HI_REG;
  assign isHi   = mdioReg == HI_REG;
  assign isPage = mdioReg == PAGE_REG;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    case (state)
      IDLE: begin
        if (mdioReq) begin
          if (mdioWrite) begin
            strb.loadPage = isPage;
            strb.loadLow  = isLow;
            strb.issueWr  = isHi;
          end else if (isLow) begin
            strb.issueRd = 1'b1;
            stateNxt     = RD_BUS;
          end else begin
            strb.respDirect = 1'b1;
          end
        end
      end
      RD_BUS: stateNxt = RD_CAP;
      RD_CAP: begin
        strb.captureRd = 1'b1;
        stateNxt       = IDLE;
      end
      default: stateNxt = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else       state <= stateNxt;
  end

  // R7
  unused_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdioReq && mdioReg > HI_REG && mdioReg != PAGE_REG)
      |-> !(strb.loadPage || strb.loadLow || strb.issueWr || strb.issueRd));
endmodule

// File: rtl/mpb_datapath.sv
module mpb_datapath
  import mpb_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int IDX_W  = 4,
  parameter int HALF_W = 16,
  parameter int REG_W  = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrb_t                  strb,
  input  logic [REG_W-1:0]          mdioReg,
  input  logic [HALF_W-1:0]         mdioWdata,
  output logic [HALF_W-1:0]         mdioRdata,
  output logic                      mdioRvalid,
  output logic [PAGE_W+IDX_W+1:0]   busAddr,
  output logic [2*HALF_W-1:0]       busWdata,
  output logic                      busWe,
  output logic                      busRe,
  input  logic [2*HALF_W-1:0]       busRdata
);
  localparam logic [REG_W-1:0] HI_REG   = REG_W'(2 ** IDX_W);
  localparam logic [REG_W-1:0] PAGE_REG = REG_W'(2 ** REG_W - 1);

  logic [PAGE_W-1:0] page;
  logic [HALF_W-1:0] loHold;
  logic [IDX_W-1:0]  wrIdx;
  logic [HALF_W-1:0] hiHold;
  logic [HALF_W-1:0] directData;

  always_comb begin
    if (mdioReg == HI_REG)        directData = hiHold;
    else if (mdioReg == PAGE_REG) directData = HALF_W'(page);
    else                          directData = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      page       <= '0;
      loHold     <= '0;
      wrIdx      <= '0;
      hiHold     <= '0;
      busAddr    <= '0;
      busWdata   <= '0;
      busWe      <= 1'b0;
      busRe      <= 1'b0;
      mdioRdata  <= '0;
      mdioRvalid <= 1'b0;
    end else begin
      busWe      <= strb.issueWr;
      busRe      <= strb.issueRd;
      mdioRvalid <= strb.captureRd || strb.respDirect;
      if (strb.loadPage) page <= mdioWdata[PAGE_W-1:0];
      if (strb.loadLow) begin
        loHold <= mdioWdata;
        wrIdx  <= mdioReg[IDX_W-1:0];
      end
      if (strb.issueWr) begin
        busAddr  <= {page, wrIdx, 2'b00};
        busWdata <= {mdioWdata, loHold};
      end
      if (strb.issueRd) busAddr <= {page, mdioReg[IDX_W-1:0], 2'b00};
      if (strb.captureRd) begin
        mdioRdata <= busRdata[HALF_W-1:0];
        hiHold    <= busRdata[2*HALF_W-1:HALF_W];
      end
      if (strb.respDirect) mdioRdata <= directData;
    end
  end

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWe |=> !busWe);
  // R5
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRe |-> strb.captureRd == 1'b0 ##1 strb.captureRd);
  // R4
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busRe));
  // R2
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadPage |=> $stable(page));
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mpb_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int IDX_W  = 4,
  parameter int HALF_W = 16,
  parameter int REG_W  = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    mdioReq,
  input  logic                    mdioWrite,
  input  logic [REG_W-1:0]        mdioReg,
  input  logic [HALF_W-1:0]       mdioWdata,
  output logic [HALF_W-1:0]       mdioRdata,
  output logic                    mdioRvalid,
  output logic [PAGE_W+IDX_W+1:0] busAddr,
  output logic [2*HALF_W-1:0]     busWdata,
  output logic                    busWe,
  output logic                    busRe,
  input  logic [2*HALF_W-1:0]     busRdata
);
  ctlStrb_t strb;

  mpb_ctrl #(.IDX_W(IDX_W), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mdioReq(mdioReq), .mdioWrite(mdioWrite),
    .mdioReg(mdioReg), .strb(strb)
  );

  mpb_datapath #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .HALF_W(HALF_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mdioReg(mdioReg), .mdioWdata(mdioWdata),
    .mdioRdata(mdioRdata), .mdioRvalid(mdioRvalid), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRe(busRe), .busRdata(busRdata)
  );
endmodule

// File: tb/mdio_page_bridge_bench.sv
`timescale 1ns/1ps
module mdio_page_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mdioReq = 1'b0;
  logic        mdioWrite = 1'b0;
  logic [4:0]  mdioReg = '0;
  logic [15:0] mdioWdata = '0;
  logic [15:0] mdioRdata;
  logic        mdioRvalid;
  logic [15:0] busAddr;
  logic [31:0] busWdata;
  logic        busWe, busRe;
  logic [31:0] busRdata = '0;

  int compared = 0, mismatched = 0;
  int weCount = 0, reCount = 0;
  logic [15:0] lastWAddr, lastRAddr;
  logic [31:0] lastWData;
  logic [31:0] mem [int unsigned];
  bit done = 0;

  always #5 clk = ~clk;

  mdio_page_bridge u_mdio_page_bridge (
    .clk(clk), .rstN(rstN), .mdioReq(mdioReq), .mdioWrite(mdioWrite),
    .mdioReg(mdioReg), .mdioWdata(mdioWdata), .mdioRdata(mdioRdata),
    .mdioRvalid(mdioRvalid), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .busRdata(busRdata)
  );

  // register-file model: data returned the cycle after the read strobe
  always @(posedge clk) begin
    if (busWe) mem[busAddr] = busWdata;
    if (busRe) busRdata <= mem.exists(busAddr) ? mem[busAddr] : 32'h0;
  end

  always @(negedge clk) begin
    if (busWe) begin weCount++; lastWAddr = busAddr; lastWData = busWdata; end
    if (busRe) begin reCount++; lastRAddr = busAddr; end
  end

  function automatic logic [31:0] expv(input logic [15:0] a);
    return ({16'h0, a} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWr(input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    mdioReq = 1'b1; mdioWrite = 1'b1; mdioReg = r; mdioWdata = d;
    @(negedge clk);
    mdioReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic doRd(input logic [4:0] r, output logic [15:0] d, output int lat);
    @(negedge clk);
    mdioReq = 1'b1; mdioWrite = 1'b0; mdioReg = r;
    @(negedge clk);
    mdioReq = 1'b0;
    lat = 1;
    while (!mdioRvalid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    d = mdioRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, a;
    logic [31:0] v;
    int lat, w0, r0;
    logic [9:0] pages [4] = '{10'h000, 10'h001, 10'h155, 10'h3FF};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busWe", {31'h0, busWe}, 32'h0);
    chk("R1 busRe", {31'h0, busRe}, 32'h0);
    chk("R1 rvalid", {31'h0, mdioRvalid}, 32'h0);
    doRd(5'd31, d, lat); chk("R1 page", {16'h0, d}, 32'h0);
    doRd(5'd16, d, lat); chk("R1 hi", {16'h0, d}, 32'h0);

    foreach (pages[p]) begin
      doWr(5'd31, {6'h0, pages[p]});
      doRd(5'd31, d, lat);
      chk("R2 page", {16'h0, d}, {22'h0, pages[p]});
      chk("R2 lat", lat, 1);
      for (int i = 0; i < 16; i++) begin
        a = {pages[p], i[3:0], 2'b00};
        v = expv(a);
        w0 = weCount;
        doWr(i[4:0], v[15:0]);
        chk("R3 no write", weCount, w0);
        doWr(5'd16, v[31:16]);
        chk("R4 one write", weCount, w0 + 1);
        chk("R4 addr", {16'h0, lastWAddr}, {16'h0, a});
        chk("R4 data", lastWData, v);
      end
      for (int i = 0; i < 16; i++) begin
        a = {pages[p], i[3:0], 2'b00};
        v = expv(a);
        r0 = reCount;
        doRd(i[4:0], d, lat);
        chk("R5 low", {16'h0, d}, {16'h0, v[15:0]});
        chk("R5 lat", lat, 3);
        chk("R5 one read", reCount, r0 + 1);
        chk("R5 addr", {16'h0, lastRAddr}, {16'h0, a});
        doRd(5'd16, d, lat);
        chk("R6 hi", {16'h0, d}, {16'h0, v[31:16]});
        chk("R6 lat", lat, 1);
        chk("R6 no read", reCount, r0 + 1);
      end
    end

    // R7 unused registers: page is 0x3FF here
    doWr(5'd2, 16'hBEEF);
    for (int r = 17; r <= 30; r++) begin
      r0 = reCount; w0 = weCount;
      doRd(r[4:0], d, lat);
      chk("R7 reads zero", {16'h0, d}, 32'h0);
      doWr(r[4:0], 16'hFFFF);
      chk("R7 no read", reCount, r0);
      chk("R7 no write", weCount, w0);
      doRd(5'd31, d, lat);
      chk("R7 page kept", {16'h0, d}, 32'h3FF);
    end
    doWr(5'd16, 16'hCAFE);
    chk("R7 low kept", lastWData, 32'hCAFEBEEF);
    chk("R7 addr", {16'h0, lastWAddr}, {16'h0, 10'h3FF, 4'd2, 2'b00});

    // R8 write index survives interleaved reads
    doWr(5'd31, 16'h0155);
    doWr(5'd3, 16'h1111);
    doRd(5'd5, d, lat);
    doRd(5'd9, d, lat);
    w0 = weCount;
    doWr(5'd16, 16'h2222);
    chk("R8 one write", weCount, w0 + 1);
    chk("R8 addr", {16'h0, lastWAddr}, {16'h0, 10'h155, 4'd3, 2'b00});
    chk("R8 data", lastWData, 32'h22221111);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule